// File: doc/BRIEF.md
# 16-bit ModRM Effective Address Generator

This unit turns the ModRM fields and displacement of an instruction that uses 16-bit addressing into either a register-operand indication or a linear memory address. It reads the eight 16-bit general registers and the base and limit of every segment. It also takes a segment-override code, the instruction's address size and a virtual-8086 flag. For memory forms it adds up to two address registers and the displacement, wraps the sum to 16 bits and picks the segment. It then applies the segment limit and adds the segment base. In virtual-8086 mode it also cuts the linear address to 20 bits.

A small two-state controller sequences the unit. In `ST_IDLE` no result is pending. The transition `GO_RESULT` is taken on any cycle with `in_valid` high, and it enters `ST_RESULT`, where `out_valid` is high for exactly one cycle. From `ST_RESULT`, `CHAIN` returns to `ST_RESULT` when a new request arrives, and `DONE` falls back to `ST_IDLE` when none does. `IDLE_WAIT` keeps `ST_IDLE` with no request. Each request is captured on the clock edge where it is presented, so results appear one cycle later.

Top module: `eag16_top`

## Requirements
- R1: For memory forms, in_rm selects the address registers: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. Register indices within in_gpr are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7, and register i occupies bits [16i+15:16i].
- R2: When in_mod is 3, out_is_reg is 1 and out_reg_idx equals in_rm. In this case out_linear and out_seg are 0 and no limit check takes place.
- R3: When in_mod is 0 and in_rm is 6, no register contributes, and the effective address is the full 16-bit in_disp.
- R4: In all other memory forms, the displacement is added according to in_mod. For mod 0 nothing is added. For mod 1, in_disp[7:0] is sign-extended to 16 bits. For mod 2, all 16 bits of in_disp are added.
- R5: The effective address is the register and displacement sum truncated to 16 bits.
- R6: An active in_seg_ovr_en selects segment in_seg_ovr. Otherwise, forms whose first register is BP (rm 2, 3, and rm 6 with mod not 0) use SS, and every other form uses DS. Segment codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5, and an override code of 6 or 7 raises out_err.
- R7: Outside virtual-8086 mode, an effective address greater than the chosen segment's limit raises out_err. An address equal to the limit is accepted.
- R8: out_linear is the effective address plus the segment base. When in_v86 is 1, out_linear is masked to its low 20 bits and the limit is never checked.
- R9: An in_addr_size other than 2 raises out_err, whatever the ModRM fields are.
- R10: A request presented with in_valid is answered exactly one cycle later by a single-cycle out_valid. out_err is only ever high together with out_valid. On an error, out_is_reg, out_reg_idx, out_seg and out_linear are all 0.
- R11: After reset, out_valid and out_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_mod | input | 2 | ModRM mod field |
| in_rm | input | 3 | ModRM rm field |
| in_disp | input | 16 | Displacement as fetched (low byte used for mod 1) |
| in_gpr | input | 128 | Eight 16-bit general registers, packed |
| in_seg_ovr_en | input | 1 | Segment override present |
| in_seg_ovr | input | 3 | Override segment code |
| in_seg_base | input | 192 | Six 32-bit segment bases, packed by segment code |
| in_seg_limit | input | 192 | Six 32-bit segment limits, packed by segment code |
| in_addr_size | input | 4 | Address size in bytes |
| in_v86 | input | 1 | Virtual-8086 mode |
| out_valid | output | 1 | Result strobe |
| out_is_reg | output | 1 | Operand is a register |
| out_reg_idx | output | 3 | Register index for register operands |
| out_seg | output | 3 | Segment used for the memory operand |
| out_linear | output | 32 | Linear address |
| out_err | output | 1 | Error flag |

## Verification
The bench builds the unit with its defaults: 16-bit registers, six segments, 32-bit bases and limits, and a 20-bit virtual-8086 window. Because the linear width exceeds 20 bits, a segment base near 1 MiB plus a small offset carries into bit 20. This makes the virtual-8086 mask directly visible. The full-width limits let the bench place the limit exactly at and just below an effective address. This exercises the boundary of the comparison.

// File: rtl/eag16_pkg.sv
package eag16_pkg;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_code_e;

    localparam logic [2:0] GPR_BX = 3'd3;
    localparam logic [2:0] GPR_BP = 3'd5;
    localparam logic [2:0] GPR_SI = 3'd6;
    localparam logic [2:0] GPR_DI = 3'd7;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } eag_state_e;

endpackage

// File: rtl/eag16_pair_sel.sv
module eag16_pair_sel
    import eag16_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int NUM_GPR = 8
) (
    input  logic [1:0]               mod_f,
    input  logic [2:0]               rm_f,
    input  logic [NUM_GPR*REG_W-1:0] gpr_flat,
    output logic [REG_W-1:0]         val_a,
    output logic [REG_W-1:0]         val_b,
    output logic                     first_is_bp
);

    logic [2:0] idx_a;
    logic [2:0] idx_b;
    logic       use_a;
    logic       use_b;

    always_comb begin
        idx_a = GPR_BX;
        idx_b = GPR_SI;
        use_a = 1'b1;
        use_b = 1'b0;
        unique case (rm_f)
            3'd0: begin idx_a = GPR_BX; idx_b = GPR_SI; use_b = 1'b1; end
            3'd1: begin idx_a = GPR_BX; idx_b = GPR_DI; use_b = 1'b1; end
            3'd2: begin idx_a = GPR_BP; idx_b = GPR_SI; use_b = 1'b1; end
            3'd3: begin idx_a = GPR_BP; idx_b = GPR_DI; use_b = 1'b1; end
            3'd4: idx_a = GPR_SI;
            3'd5: idx_a = GPR_DI;
            3'd6: idx_a = GPR_BP;
            3'd7: idx_a = GPR_BX;
            default: idx_a = GPR_BX;
        endcase
        if (mod_f == 2'd0 && rm_f == 3'd6) begin
            use_a = 1'b0;
        end
    end

    assign val_a       = use_a ? gpr_flat[int'(idx_a)*REG_W +: REG_W] : '0;
    assign val_b       = use_b ? gpr_flat[int'(idx_b)*REG_W +: REG_W] : '0;
    assign first_is_bp = use_a && (idx_a == GPR_BP);

endmodule

// File: rtl/eag16_disp_ext.sv
module eag16_disp_ext #(
    parameter int REG_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [1:0]       mod_f,
    input  logic [2:0]       rm_f,
    input  logic [REG_W-1:0] disp_raw,
    output logic [REG_W-1:0] disp_eff
);

    localparam int PAD_W = REG_W - SHORT_W;

    always_comb begin
        unique case (mod_f)
            2'd0: disp_eff = (rm_f == 3'd6) ? disp_raw : '0;
            2'd1: disp_eff = {{PAD_W{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
            2'd2: disp_eff = disp_raw;
            default: disp_eff = '0;
        endcase
    end

endmodule

// File: rtl/eag16_seg_check.sv
module eag16_seg_check #(
    parameter int REG_W   = 16,
    parameter int LIN_W   = 32,
    parameter int NUM_SEG = 6,
    parameter int V86_W   = 20
) (
    input  logic [REG_W-1:0]         eff_addr,
    input  logic [2:0]               seg_sel,
    input  logic                     v86,
    input  logic [NUM_SEG*LIN_W-1:0] base_flat,
    input  logic [NUM_SEG*LIN_W-1:0] limit_flat,
    output logic [LIN_W-1:0]         linear,
    output logic                     lim_err,
    output logic                     seg_err
);

    logic [LIN_W-1:0] base_sel;
    logic [LIN_W-1:0] limit_sel;
    logic [LIN_W-1:0] ea_wide;
    logic [LIN_W-1:0] sum;

    assign seg_err   = (int'(seg_sel) >= NUM_SEG);
    assign base_sel  = seg_err ? '0 : base_flat[int'(seg_sel)*LIN_W +: LIN_W];
    assign limit_sel = seg_err ? '0 : limit_flat[int'(seg_sel)*LIN_W +: LIN_W];
    assign ea_wide   = {{(LIN_W-REG_W){1'b0}}, eff_addr};
    assign sum       = ea_wide + base_sel;
    assign lim_err   = !v86 && (ea_wide > limit_sel);

    generate
        if (LIN_W > V86_W) begin : g_mask
            assign linear = v86 ? {{(LIN_W-V86_W){1'b0}}, sum[V86_W-1:0]} : sum;
        end else begin : g_nomask
            assign linear = sum;
        end
    endgenerate

endmodule

// File: rtl/eag16_top.sv
module eag16_top
    import eag16_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int NUM_GPR    = 8,
    parameter int LIN_W      = 32,
    parameter int NUM_SEG    = 6,
    parameter int V86_W      = 20,
    parameter int ADDR_BYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_mod,
    input  logic [2:0]               in_rm,
    input  logic [REG_W-1:0]         in_disp,
    input  logic [NUM_GPR*REG_W-1:0] in_gpr,
    input  logic                     in_seg_ovr_en,
    input  logic [2:0]               in_seg_ovr,
    input  logic [NUM_SEG*LIN_W-1:0] in_seg_base,
    input  logic [NUM_SEG*LIN_W-1:0] in_seg_limit,
    input  logic [3:0]               in_addr_size,
    input  logic                     in_v86,
    output logic                     out_valid,
    output logic                     out_is_reg,
    output logic [2:0]               out_reg_idx,
    output logic [2:0]               out_seg,
    output logic [LIN_W-1:0]         out_linear,
    output logic                     out_err
);

    eag_state_e state_q;
    eag_state_e state_d;

    logic [REG_W-1:0] val_a;
    logic [REG_W-1:0] val_b;
    logic             first_is_bp;
    logic [REG_W-1:0] disp_eff;
    logic [REG_W-1:0] eff_addr;
    logic [2:0]       seg_sel;
    logic [LIN_W-1:0] linear_c;
    logic             lim_err;
    logic             seg_err;
    logic             size_err;
    logic             is_reg_c;
    logic             err_c;

    eag16_pair_sel #(.REG_W(REG_W), .NUM_GPR(NUM_GPR)) i_pair (
        .mod_f       (in_mod),
        .rm_f        (in_rm),
        .gpr_flat    (in_gpr),
        .val_a       (val_a),
        .val_b       (val_b),
        .first_is_bp (first_is_bp)
    );

    eag16_disp_ext #(.REG_W(REG_W)) i_disp (
        .mod_f    (in_mod),
        .rm_f     (in_rm),
        .disp_raw (in_disp),
        .disp_eff (disp_eff)
    );

    assign eff_addr = val_a + val_b + disp_eff;
    assign seg_sel  = in_seg_ovr_en ? in_seg_ovr : (first_is_bp ? SEG_SS : SEG_DS);

    eag16_seg_check #(.REG_W(REG_W), .LIN_W(LIN_W), .NUM_SEG(NUM_SEG), .V86_W(V86_W)) i_seg (
        .eff_addr   (eff_addr),
        .seg_sel    (seg_sel),
        .v86        (in_v86),
        .base_flat  (in_seg_base),
        .limit_flat (in_seg_limit),
        .linear     (linear_c),
        .lim_err    (lim_err),
        .seg_err    (seg_err)
    );

    assign size_err = (in_addr_size != 4'(ADDR_BYTES));
    assign is_reg_c = (in_mod == 2'd3);
    assign err_c    = size_err || (!is_reg_c && (lim_err || seg_err));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state: GO_RESULT / CHAIN on a request, DONE / IDLE_WAIT otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_err     <= 1'b0;
            out_is_reg  <= 1'b0;
            out_reg_idx <= '0;
            out_seg     <= '0;
            out_linear  <= '0;
        end else if (in_valid) begin
            out_err     <= err_c;
            out_is_reg  <= !err_c && is_reg_c;
            out_reg_idx <= (!err_c && is_reg_c) ? in_rm : 3'd0;
            out_seg     <= (!err_c && !is_reg_c) ? seg_sel : 3'd0;
            out_linear  <= (!err_c && !is_reg_c) ? linear_c : '0;
        end else begin
            out_err     <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    // Assertions
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_err_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
    assert_regop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mod == 2'd3 && in_addr_size == 4'(ADDR_BYTES))
        |=> (out_is_reg && !out_err && out_reg_idx == $past(in_rm) && out_linear == '0));
    assert_size_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr_size != 4'(ADDR_BYTES)) |=> (out_err && !out_is_reg));
    assert_v86_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_v86) |=> ((out_linear >> V86_W) == '0));
    assert_v86_nolimit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_v86 && !in_seg_ovr_en && in_addr_size == 4'(ADDR_BYTES)) |=> !out_err);
    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_err));

endmodule

// File: tb/test_eag16_top.sv
module test_eag16_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mod = '0;
    logic [2:0]   in_rm = '0;
    logic [15:0]  in_disp = '0;
    logic [127:0] in_gpr;
    logic         in_seg_ovr_en = 1'b0;
    logic [2:0]   in_seg_ovr = '0;
    logic [191:0] in_seg_base;
    logic [191:0] in_seg_limit;
    logic [3:0]   in_addr_size = 4'd2;
    logic         in_v86 = 1'b0;
    logic         out_valid, out_is_reg, out_err;
    logic [2:0]   out_reg_idx, out_seg;
    logic [31:0]  out_linear;

    logic [15:0] gpr [8];
    logic [31:0] sbase [6];
    logic [31:0] slim [6];

    always_comb begin
        for (int i = 0; i < 8; i++) in_gpr[i*16 +: 16] = gpr[i];
        for (int i = 0; i < 6; i++) begin
            in_seg_base[i*32 +: 32]  = sbase[i];
            in_seg_limit[i*32 +: 32] = slim[i];
        end
    end

    always #4 clk = ~clk;

    eag16_top i_eag16_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod), .in_rm(in_rm),
        .in_disp(in_disp), .in_gpr(in_gpr), .in_seg_ovr_en(in_seg_ovr_en),
        .in_seg_ovr(in_seg_ovr), .in_seg_base(in_seg_base), .in_seg_limit(in_seg_limit),
        .in_addr_size(in_addr_size), .in_v86(in_v86), .out_valid(out_valid),
        .out_is_reg(out_is_reg), .out_reg_idx(out_reg_idx), .out_seg(out_seg),
        .out_linear(out_linear), .out_err(out_err)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic        e_err, e_is_reg;
    logic [2:0]  e_idx, e_seg;
    logic [31:0] e_lin;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference prediction from the requirements
    task automatic predict();
        logic [15:0] a, b, d, ea;
        logic [2:0]  s;
        bit          bp, err;
        int          r1, r2;
        e_err = 0; e_is_reg = 0; e_idx = 0; e_seg = 0; e_lin = 0;
        if (in_addr_size != 4'd2) begin e_err = 1; return; end
        if (in_mod == 2'd3) begin e_is_reg = 1; e_idx = in_rm; return; end
        r1 = -1; r2 = -1;
        case (in_rm)
            3'd0: begin r1 = 3; r2 = 6; end
            3'd1: begin r1 = 3; r2 = 7; end
            3'd2: begin r1 = 5; r2 = 6; end
            3'd3: begin r1 = 5; r2 = 7; end
            3'd4: r1 = 6;
            3'd5: r1 = 7;
            3'd6: r1 = (in_mod == 2'd0) ? -1 : 5;
            default: r1 = 3;
        endcase
        a = (r1 >= 0) ? gpr[r1] : 16'h0;
        b = (r2 >= 0) ? gpr[r2] : 16'h0;
        if (in_mod == 2'd1) d = {{8{in_disp[7]}}, in_disp[7:0]};
        else if (in_mod == 2'd2 || in_rm == 3'd6) d = in_disp;
        else d = 16'h0;
        ea = a + b + d;
        bp = (r1 == 5);
        s = in_seg_ovr_en ? in_seg_ovr : (bp ? 3'd2 : 3'd3);
        err = (s > 3'd5);
        if (!err && !in_v86 && {16'h0, ea} > slim[s]) err = 1;
        if (err) begin e_err = 1; return; end
        e_seg = s;
        e_lin = {16'h0, ea} + sbase[s];
        if (in_v86) e_lin = e_lin & 32'h000F_FFFF;
    endtask

    task automatic run(string req);
        predict();
        @(negedge clk);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk(req, "valid", {31'h0, out_valid}, 32'h1);
        chk(req, "err", {31'h0, out_err}, {31'h0, e_err});
        chk(req, "is_reg", {31'h0, out_is_reg}, {31'h0, e_is_reg});
        chk(req, "reg_idx", {29'h0, out_reg_idx}, {29'h0, e_idx});
        chk(req, "seg", {29'h0, out_seg}, {29'h0, e_seg});
        chk(req, "linear", out_linear, e_lin);
    endtask

    task automatic setup(logic [1:0] m, logic [2:0] r, logic [15:0] d);
        in_mod = m; in_rm = r; in_disp = d;
        in_seg_ovr_en = 0; in_seg_ovr = 0; in_addr_size = 4'd2; in_v86 = 0;
    endtask

    task automatic t_reset_R11();
        chk("R11", "valid", {31'h0, out_valid}, 32'h0);
        chk("R11", "err", {31'h0, out_err}, 32'h0);
    endtask

    task automatic t_pairs_R1();
        for (int r = 0; r < 8; r++) begin setup(2'd0, 3'(r), 16'h0); if (r != 6) run("R1"); end
        for (int r = 0; r < 8; r++) begin setup(2'd2, 3'(r), 16'h0100); run("R1"); end
    endtask

    task automatic t_regop_R2();
        for (int r = 0; r < 8; r++) begin setup(2'd3, 3'(r), 16'hFFFF); run("R2"); end
    endtask

    task automatic t_disp_only_R3();
        setup(2'd0, 3'd6, 16'hBEEF); run("R3");
    endtask

    task automatic t_disp_modes_R4();
        setup(2'd1, 3'd7, 16'h1280); run("R4");
        setup(2'd1, 3'd7, 16'hAB7F); run("R4");
        setup(2'd2, 3'd4, 16'h8001); run("R4");
        setup(2'd0, 3'd4, 16'h7777); run("R4");
    endtask

    task automatic t_wrap_R5();
        gpr[3] = 16'hFFF0; gpr[6] = 16'h0020;
        setup(2'd2, 3'd0, 16'h0010); run("R5");
        setup(2'd1, 3'd0, 16'h00F0); run("R5");
        gpr[3] = 16'h1000; gpr[6] = 16'h0030;
    endtask

    task automatic t_segment_R6();
        setup(2'd1, 3'd6, 16'h0004); run("R6");
        setup(2'd2, 3'd3, 16'h0000); run("R6");
        setup(2'd1, 3'd2, 16'h0004); in_seg_ovr_en = 1; in_seg_ovr = 3'd0; run("R6");
        setup(2'd0, 3'd7, 16'h0000); in_seg_ovr_en = 1; in_seg_ovr = 3'd5; run("R6");
        setup(2'd0, 3'd7, 16'h0000); in_seg_ovr_en = 1; in_seg_ovr = 3'd6; run("R6");
    endtask

    task automatic t_limit_R7();
        // BX+SI with mod 0: 0x1030 in DS
        slim[3] = 32'h0000_1030; setup(2'd0, 3'd0, 16'h0); run("R7");
        slim[3] = 32'h0000_102F; setup(2'd0, 3'd0, 16'h0); run("R7");
        setup(2'd0, 3'd0, 16'h0); in_v86 = 1; run("R7");
        slim[3] = 32'h0000_FFFF;
    endtask

    task automatic t_v86_R8();
        sbase[3] = 32'h000F_FFF0;
        setup(2'd0, 3'd6, 16'h0020); run("R8");
        setup(2'd0, 3'd6, 16'h0020); in_v86 = 1; run("R8");
        sbase[3] = 32'h0004_0000;
    endtask

    task automatic t_size_R9();
        setup(2'd2, 3'd0, 16'h0); in_addr_size = 4'd4; run("R9");
        setup(2'd3, 3'd1, 16'h0); in_addr_size = 4'd8; run("R9");
    endtask

    task automatic t_strobe_R10();
        setup(2'd0, 3'd7, 16'h0); run("R10");
        @(negedge clk);
        chk("R10", "valid drops", {31'h0, out_valid}, 32'h0);
        chk("R10", "err drops", {31'h0, out_err}, 32'h0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        gpr[0] = 16'h1111; gpr[1] = 16'h2222; gpr[2] = 16'h3333; gpr[3] = 16'h1000;
        gpr[4] = 16'h5555; gpr[5] = 16'h2000; gpr[6] = 16'h0030; gpr[7] = 16'h0004;
        for (int i = 0; i < 6; i++) begin
            sbase[i] = 32'(i + 1) << 16;
            slim[i]  = 32'h0000_FFFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_R11();
        t_pairs_R1();
        t_regop_R2();
        t_disp_only_R3();
        t_disp_modes_R4();
        t_wrap_R5();
        t_segment_R6();
        t_limit_R7();
        t_v86_R8();
        t_size_R9();
        t_strobe_R10();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule